// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronization

This block is the timing core of one PWM channel. A 16-bit counter runs against a programmable period value, which sets the PWM frequency. In the single-edge mode the counter ramps up and wraps. In the center-aligned mode it ramps up to the period and back down to zero, which gives symmetric dual-edge waveforms. The counter value, a zero-match strobe, a period-match strobe and a direction flag are the outputs. Downstream compare and action logic uses them to shape the PWM edges.

Several copies of the block can be chained. Each copy drives a sync output into the sync input of the next copy. A stage whose sync input is enabled reloads a programmable phase value when a sync event arrives. The stages therefore stay locked to one another at a chosen lead or lag. In the center-aligned mode, a control bit selects the direction in which counting resumes after the reload. Each stage chooses its sync output from two sources: its own zero-match strobe, or the incoming sync routed straight through. Routing the sync straight through lets a sync event reach several stages in the same cycle.

Top module: `pwmTimebase`

## Requirements
- R1: While reset (`rstN` low) is asserted and after it is released: `count` is 0, `countingDown` is 0 and `atZero` is 1.
- R2: With `countMode`=0, no phase load and `periodVal`>0:
  - `count` rises by one on each clock while it is below `periodVal`.
  - On the clock after `count` is at or above `periodVal`, `count` becomes 0.
  - One waveform period is therefore `periodVal`+1 clocks.
- R3: With `countMode`=1, no phase load and `periodVal`>0:
  - `count` runs 0,1,…,P,P-1,…,1,0,1,… so one waveform period is 2·P clocks.
  - `countingDown` is 1 exactly when the most recent step was a decrement.
- R4: With `periodVal`=0 and no phase load, `count` stays 0 and `countingDown` stays 0 in both modes.
- R5: If `syncInEn` and `syncIn` are both 1 at a rising clock edge, `count` equals `phaseVal` after that edge. This overrides normal counting. Counting resumes from that value under R2 and R3, and a loaded value above `periodVal` is handled like any count at or past the period.
- R6: With `syncInEn`=0, `syncIn` has no effect on `count` or `countingDown`.
- R7: On a phase load with `countMode`=1, `countingDown` becomes 0 if `phaseDirUp`=1 and becomes 1 otherwise. With `countMode`=0, `countingDown` is 0 after every clock.
- R8: `atZero` is 1 exactly when `count` is 0, and `atPeriod` is 1 exactly when `count` equals `periodVal`. With `periodVal`>0 and no phase load, each is a one-clock pulse.
- R9: The sync output is combinational in the same cycle:
  - With `syncOutSel`=0, `syncOut` equals `atZero`.
  - With `syncOutSel`=1, `syncOut` equals `syncIn`, whatever the value of `syncInEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodVal | input | 16 | Period value (count limit) |
| phaseVal | input | 16 | Value loaded on a qualified sync event |
| countMode | input | 1 | 0 = up count with wrap, 1 = up-down count |
| syncInEn | input | 1 | 1 = a sync input reloads the phase value |
| syncIn | input | 1 | Sync from the previous stage |
| syncOutSel | input | 1 | 0 = sync out on zero match, 1 = pass `syncIn` through |
| phaseDirUp | input | 1 | Direction after a phase load in up-down mode (1 = up) |
| count | output | 16 | Current counter value |
| atZero | output | 1 | Counter equals zero |
| atPeriod | output | 1 | Counter equals period |
| countingDown | output | 1 | Most recent step was a decrement |
| syncOut | output | 1 | Sync to the next stage |

## Verification
The assertions check the following on every cycle:
- a qualified sync makes `count` equal the sampled phase on the next clock;
- a counter below its limit moves by exactly one step in either mode;
- a zero period holds the counter at zero;
- the match strobes last only one clock;
- the control never issues two counter strobes at once.

Some behaviours are only visible in the bench's scenarios:
- the full shape of each waveform for every period, compared against closed-form sequences;
- the wrap and turnaround points;
- the direction flag's value after every combination of phase value, load time, direction bit and mode, including phase values above the period;
- the choice between the two sync-output sources.

// File: rtl/pwmTimebasePkg.sv
package pwmTimebasePkg;

  // Counting style selected by the countMode input.
  typedef enum logic {
    MODE_UP     = 1'b0,
    MODE_UPDOWN = 1'b1
  } cntMode_e;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic loadPhase;
    logic clear;
    logic incr;
    logic decr;
  } cntStrobe_t;

endpackage

// File: rtl/pwmTbDatapath.sv
module pwmTbDatapath
  import pwmTimebasePkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] countQ,
  output logic             isZero,
  output logic             isPeriod,
  output logic             atOrPast,
  output logic             periodIsZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (strobe.loadPhase)  countNext = phaseVal;
    else if (strobe.clear) countNext = '0;
    else if (strobe.incr)  countNext = countQ + ONE;
    else if (strobe.decr)  countNext = countQ - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countNext;
  end

  // Compare results handed back to control and to the outputs.
  assign isZero       = (countQ == '0);
  assign isPeriod     = (countQ == periodVal);
  assign atOrPast     = (countQ >= periodVal);
  assign periodIsZero = (periodVal == '0);

  // R2/R3: control must never request two counter operations in one cycle.
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadPhase, strobe.clear, strobe.incr, strobe.decr}));

endmodule

// File: rtl/pwmTbControl.sv
module pwmTbControl
  import pwmTimebasePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cntMode_e   mode,
  input  logic       syncHit,
  input  logic       phaseDirUp,
  input  logic       isZero,
  input  logic       atOrPast,
  input  logic       periodIsZero,
  output cntStrobe_t strobe,
  output logic       dirDown
);

  logic dirNext;

  always_comb begin
    strobe  = '0;
    dirNext = dirDown;
    if (syncHit) begin
      strobe.loadPhase = 1'b1;
      dirNext          = (mode == MODE_UPDOWN) ? !phaseDirUp : 1'b0;
    end else if (mode == MODE_UP) begin
      dirNext = 1'b0;
      if (atOrPast) strobe.clear = 1'b1;
      else          strobe.incr  = 1'b1;
    end else if (periodIsZero) begin
      strobe.clear = 1'b1;
      dirNext      = 1'b0;
    end else if (!dirDown) begin
      if (atOrPast) begin
        strobe.decr = 1'b1;
        dirNext     = 1'b1;
      end else begin
        strobe.incr = 1'b1;
      end
    end else begin
      if (isZero) begin
        strobe.incr = 1'b1;
        dirNext     = 1'b0;
      end else begin
        strobe.decr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirDown <= 1'b0;
    else       dirDown <= dirNext;
  end

  // R7: single-edge mode always leaves the direction flag clear.
  p_dir_clear_up_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_UP) |=> !dirDown);

  // R3: a down-count that reaches zero turns around to up.
  p_turn_at_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_UPDOWN && !syncHit && dirDown && isZero && !periodIsZero)
      |=> !dirDown);

endmodule

// File: rtl/pwmSyncRoute.sv
module pwmSyncRoute (
  input  logic syncIn,
  input  logic zeroHit,
  input  logic passSel,
  output logic syncOut
);

  // Either forward the upstream sync or announce this stage's zero match.
  assign syncOut = passSel ? syncIn : zeroHit;

endmodule

// File: rtl/pwmTimebase.sv
module pwmTimebase
  import pwmTimebasePkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic             countMode,
  input  logic             syncInEn,
  input  logic             syncIn,
  input  logic             syncOutSel,
  input  logic             phaseDirUp,
  output logic [CNT_W-1:0] count,
  output logic             atZero,
  output logic             atPeriod,
  output logic             countingDown,
  output logic             syncOut
);

  cntStrobe_t strobe;
  logic       syncHit;
  logic       isZero;
  logic       isPeriod;
  logic       atOrPast;
  logic       periodIsZero;

  assign syncHit = syncInEn & syncIn;

  pwmTbControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .mode         (cntMode_e'(countMode)),
    .syncHit      (syncHit),
    .phaseDirUp   (phaseDirUp),
    .isZero       (isZero),
    .atOrPast     (atOrPast),
    .periodIsZero (periodIsZero),
    .strobe       (strobe),
    .dirDown      (countingDown)
  );

  pwmTbDatapath #(.CNT_W(CNT_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .phaseVal     (phaseVal),
    .periodVal    (periodVal),
    .countQ       (count),
    .isZero       (isZero),
    .isPeriod     (isPeriod),
    .atOrPast     (atOrPast),
    .periodIsZero (periodIsZero)
  );

  pwmSyncRoute uSync (
    .syncIn  (syncIn),
    .zeroHit (isZero),
    .passSel (syncOutSel),
    .syncOut (syncOut)
  );

  assign atZero   = isZero;
  assign atPeriod = isPeriod;

  // R5: a qualified sync reloads the phase value on the next clock.
  p_sync_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    syncHit |=> (count == $past(phaseVal)));

  // R2: single-edge counting below the limit advances by one.
  p_up_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!syncHit && !countMode && count < periodVal)
      |=> (count == CNT_W'($past(count) + 1'b1)));

  // R6: an unqualified sync pulse does not disturb the ramp.
  p_sync_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!syncInEn && syncIn && !countMode && count < periodVal)
      |=> (count == CNT_W'($past(count) + 1'b1)));

  // R3: up-down counting inside the range moves by exactly one.
  p_ud_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!syncHit && countMode && periodVal != '0 && count <= periodVal)
      |=> (count == CNT_W'($past(count) + 1'b1) ||
           count == CNT_W'($past(count) - 1'b1)));

  // R4: zero period pins the counter at zero.
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!syncHit && periodVal == '0) |=> (count == '0));

  // R8: match strobes last a single clock when the period is non-zero.
  p_zero_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (atZero && !syncHit && periodVal != '0) |=> !atZero);

  p_period_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (atPeriod && !syncHit && periodVal != '0) |=> (count != $past(count)));

endmodule

// File: tb/pwmTimebase_test.sv
module pwmTimebase_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] periodVal = '0;
  logic [W-1:0] phaseVal = '0;
  logic         countMode = 1'b0;
  logic         syncInEn = 1'b0;
  logic         syncIn = 1'b0;
  logic         syncOutSel = 1'b0;
  logic         phaseDirUp = 1'b0;
  logic [W-1:0] count;
  logic         atZero, atPeriod, countingDown, syncOut;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;

  pwmTimebase #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .periodVal(periodVal), .phaseVal(phaseVal),
    .countMode(countMode), .syncInEn(syncInEn), .syncIn(syncIn),
    .syncOutSel(syncOutSel), .phaseDirUp(phaseDirUp),
    .count(count), .atZero(atZero), .atPeriod(atPeriod),
    .countingDown(countingDown), .syncOut(syncOut)
  );

  // Reference sequence for sync scenarios, built from R2..R7.
  logic [W-1:0] mCount;
  logic         mDown;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount <= '0; mDown <= 1'b0;
    end else if (syncInEn && syncIn) begin
      mCount <= phaseVal; mDown <= countMode ? !phaseDirUp : 1'b0;
    end else if (!countMode) begin
      mCount <= (mCount >= periodVal) ? '0 : mCount + 16'd1; mDown <= 1'b0;
    end else if (periodVal == '0) begin
      mCount <= '0; mDown <= 1'b0;
    end else if (!mDown) begin
      if (mCount >= periodVal) begin mCount <= mCount - 16'd1; mDown <= 1'b1; end
      else mCount <= mCount + 16'd1;
    end else if (mCount == '0) begin
      mCount <= 16'd1; mDown <= 1'b0;
    end else begin
      mCount <= mCount - 16'd1;
    end
  end

  task automatic cmp(string tag, string what, int act, int expv);
    vectors++;
    if (act != expv) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic checkOut(string tc, string td, logic [W-1:0] eC, logic eD);
    cmp(tc, "count", count, eC);
    cmp(td, "countingDown", countingDown, eD);
    cmp("R8", "atZero", atZero, (eC == '0));
    cmp("R8", "atPeriod", atPeriod, (eC == periodVal));
    cmp("R9", "syncOut", syncOut, syncOutSel ? syncIn : (eC == '0));
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    checkOut("R1", "R1", '0, 1'b0);
    rstN = 1'b1;
  endtask

  // Closed-form waveform after reset: returns {down, count}.
  function automatic logic [W:0] closedForm(bit mode, int p, int n);
    int k;
    if (p == 0) return '0;
    if (!mode) return {1'b0, W'(n % (p + 1))};
    k = n % (2 * p);
    if (k <= p) return {(k == 0 && n > 0), W'(k)};
    return {1'b1, W'(2 * p - k)};
  endfunction

  task automatic modelStep(string tc, string td);
    @(posedge clk); @(negedge clk);
    checkOut(tc, td, mCount, mDown);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    periodVal = 16'd5;
    @(negedge clk);
    checkOut("R1", "R1", '0, 1'b0);

    // Free-running sweeps: R2, R3, R4, with R6 and R9 via ignored toggling syncIn.
    for (int mode = 0; mode < 2; mode++) begin
      for (int p = 0; p < 8; p++) begin
        for (int sel = 0; sel < 2; sel++) begin
          countMode  = mode[0];
          periodVal  = W'(p);
          syncOutSel = sel[0];
          syncInEn   = 1'b0;
          syncIn     = 1'b0;
          doReset();
          for (int n = 1; n <= 3 * (2 * p + 2); n++) begin
            logic [W:0] e;
            @(posedge clk); @(negedge clk);
            e = closedForm(mode[0], p, n);
            checkOut((p == 0) ? "R4" : (sel == 1) ? "R6" : (mode == 1) ? "R3" : "R2",
                     (p == 0) ? "R4" : (mode == 1) ? "R3" : "R7",
                     e[W-1:0], e[W]);
            syncIn = (sel == 1) ? (n[0] ^ n[2]) : 1'b0;
          end
        end
      end
    end

    // Phase loads: R5 and R7, including phases above the period.
    periodVal = 16'd5;
    for (int mode = 0; mode < 2; mode++) begin
      for (int dirUp = 0; dirUp < 2; dirUp++) begin
        for (int ph = 0; ph < 9; ph++) begin
          for (int d = 0; d < 9; d += 4) begin
            countMode  = mode[0];
            phaseDirUp = dirUp[0];
            phaseVal   = W'(ph);
            syncOutSel = ph[0];
            syncInEn   = 1'b1;
            syncIn     = 1'b0;
            doReset();
            for (int i = 0; i < d; i++) modelStep("R5", "R7");
            syncIn = 1'b1;
            @(posedge clk); @(negedge clk);
            checkOut("R5", "R7", W'(ph), mode[0] ? !dirUp[0] : 1'b0);
            syncIn = 1'b0;
            for (int i = 0; i < 14; i++) modelStep("R5", "R7");
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule